// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a downstream FPGA through its serial configuration pins. A start pulse, sampled together with a byte count, launches the sequence. First comes the reset handshake: the active-low program pin is pulled low until the FPGA pulls its INIT line low. The program pin is then released, and the block waits for INIT to return high. Each wait has its own timeout.

The block then takes configuration bytes from a valid/ready stream. It shifts each byte out most significant bit first, on a serial clock whose phase length is set by a prescaler. Before it takes each byte, it looks for a load error, which is INIT pulled low while DONE is still low. After the last byte it holds the data line high and keeps pulsing the serial clock until DONE rises, or until the timeout ends the run. A one-cycle finish pulse reports a 3-bit result code.

The INIT and DONE lines come from another device. Each passes through a two-flop synchroniser before the sequencer uses it.

Top module: `sscfg_loader`

## Requirements
- R1: Out of reset and whenever not busy: program pin released (1), serial clock low, ready low, busy low. Status reads 0 after reset.
- R2: A start pulse drives the program pin low until INIT is seen low. If that takes longer than TMO_CYC cycles, the run ends with status 1.
- R3: Once INIT is seen low, the program pin is released and the block waits for INIT high under a freshly restarted timeout. On expiry the run ends with status 2.
- R4: Bytes are shifted out most significant bit first, 8 bits per byte. The data line changes only while the serial clock is low, so the FPGA samples on the rising edge.
- R5: Inside a byte, each bit spends 2*DLY_CYC system clocks with the serial clock low and DLY_CYC with it high. The data bit is presented after the first DLY_CYC of the low phase.
- R6: A byte is taken only when valid and ready are both high. Ready is high only in the byte-load state, while the program pin is released; with valid low no clock pulse is issued.
- R7: Before each byte, and before the trailing phase, DONE low together with INIT low ends the run with status 3. No further byte is taken.
- R8: After the last byte the data line is 1 on every further clock pulse. Pulses continue until DONE is seen high, and then the run ends with status 0.
- R9: If DONE is not seen high within TMO_CYC cycles of the trailing phase starting, the run ends with status 4.
- R10: Every run ends with exactly one single-cycle finish pulse, coincident with busy falling and with the status of that run.
- R11: A start pulse while busy is ignored: neither the byte count nor the run in progress changes.
- R12: A byte count of 0 skips the data phase and goes straight to the trailing clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| nbytes_i | input | CNT_W | Byte count sampled with start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream ready, high in the byte-load state |
| prog_n_o | output | 1 | Active-low program pin |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Active-low INIT from the FPGA (asynchronous) |
| done_i | input | 1 | DONE from the FPGA (asynchronous) |
| busy_o | output | 1 | A run is in progress |
| fin_o | output | 1 | One-cycle pulse at the end of a run |
| status_o | output | 3 | Result: 0 ok, 1 INIT-low timeout, 2 INIT-high timeout, 3 load error, 4 DONE timeout |

## Verification
A sequencer stuck in the wrong state shows up on the pins within one prescaler phase. Ready may rise with the program pin low. The serial clock may stop toggling while busy stays high. The data line may change during a high clock phase. A corrupted bit counter shows up on the next byte the FPGA model captures, as a wrong value or as a bit low phase that is not 2*DLY_CYC long. A faulty timeout counter shows up within TMO_CYC cycles as a wrong status code or a run that never finishes.

// File: rtl/sscfg_pkg.sv
// Shared types for the serial configuration loader: result codes and
// sequencer states. Assumes a 3-bit status field at the top level.
package sscfg_pkg;

    typedef enum logic [2:0] {
        ST_OK          = 3'd0,
        ST_INIT_LO_TMO = 3'd1,
        ST_INIT_HI_TMO = 3'd2,
        ST_LOAD_ERR    = 3'd3,
        ST_DONE_TMO    = 3'd4
    } cfg_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROG,
        S_REL,
        S_CHECK,
        S_LOAD,
        S_CLKLO,
        S_DATA,
        S_CLKHI,
        S_TCHK,
        S_THI,
        S_TLO
    } cfg_state_e;

endpackage

// File: rtl/sscfg_sync.sv
// Two-flop synchroniser for one asynchronous level input.
// Assumes the input is a slow level; RST_VAL is its inactive value.
module sscfg_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q, sync_q;

    // Two register stages in series to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/sscfg_tick.sv
// Phase prescaler: while clr_i is low it raises hit_o once every CYC
// cycles. hit_o also restarts the count, so chained phases each last
// exactly CYC cycles. Assumes CYC >= 1.
module sscfg_tick #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic hit_o
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;

    assign hit_o = !clr_i && (cnt_q == LAST);

    // Count cycles inside a timed phase; restart on clear or on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || hit_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST) else $error("prescaler count past phase end"); // R5
endmodule

// File: rtl/sscfg_tmo.sv
// Wait-phase timeout: counts while clr_i is low and saturates at
// LIMIT, where exp_o stays high until the next clear.
module sscfg_tmo #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic exp_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    assign exp_o = (cnt_q == TOP);

    // Saturating cycle counter for the current wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (!exp_o) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_TMO_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        exp_o && !clr_i |=> exp_o || $past(clr_i)) else $error("timeout flag dropped"); // R9
endmodule

// File: rtl/sscfg_loader.sv
// Serial FPGA configuration sequencer. Runs the program/INIT handshake,
// streams bytes MSB first on a prescaled serial clock, checks for a load
// error before each byte, then clocks with data high until DONE.
// Assumes init_n_i / done_i are asynchronous and nbytes_i is valid with start_i.
module sscfg_loader
    import sscfg_pkg::*;
#(
    parameter int DLY_CYC = 4,
    parameter int TMO_CYC = 100000,
    parameter int CNT_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    output logic             prog_n_o,
    output logic             cclk_o,
    output logic             din_o,
    input  logic             init_n_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [2:0]       status_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [2:0]       BIT_LAST = 3'd7;

    cfg_state_e       state_q;
    cfg_status_e      status_q, fin_code;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic             prog_n_q, cclk_q, din_q, fin_q;
    logic             init_n_s, done_s;
    logic             timed, in_wait, tick_hit, tmo_clr, tmo_exp, fin_now;

    sscfg_sync #(.RST_VAL(1'b1)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .d_i(init_n_i), .q_o(init_n_s));
    sscfg_sync #(.RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst_n(rst_n), .d_i(done_i), .q_o(done_s));

    // Phases whose length comes from the prescaler.
    always_comb begin
        timed = (state_q == S_CLKLO) || (state_q == S_DATA) || (state_q == S_CLKHI)
             || (state_q == S_THI)   || (state_q == S_TLO);
    end

    // Phases covered by the timeout; a new phase restarts the counter.
    always_comb begin
        in_wait = (state_q == S_PROG) || (state_q == S_REL) || (state_q == S_TCHK)
               || (state_q == S_THI)  || (state_q == S_TLO);
        tmo_clr = !in_wait || ((state_q == S_PROG) && !init_n_s);
    end

    sscfg_tick #(.CYC(DLY_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(!timed), .hit_o(tick_hit));
    sscfg_tmo #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr_i(tmo_clr), .exp_o(tmo_exp));

    // Decide whether this cycle ends the run, and with which code.
    always_comb begin
        fin_now  = 1'b0;
        fin_code = ST_OK;
        case (state_q)
            S_PROG:  if (init_n_s && tmo_exp) begin fin_now = 1'b1; fin_code = ST_INIT_LO_TMO; end
            S_REL:   if (!init_n_s && tmo_exp) begin fin_now = 1'b1; fin_code = ST_INIT_HI_TMO; end
            S_CHECK: if (!done_s && !init_n_s) begin fin_now = 1'b1; fin_code = ST_LOAD_ERR; end
            S_TCHK: begin
                if (done_s) begin
                    fin_now = 1'b1; fin_code = ST_OK;
                end else if (tmo_exp) begin
                    fin_now = 1'b1; fin_code = ST_DONE_TMO;
                end
            end
            default: ;
        endcase
    end

    // Sequencer: state, pin registers, byte shifter and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_OK;
            rem_q    <= '0;
            sh_q     <= '0;
            bit_q    <= '0;
            prog_n_q <= 1'b1;
            cclk_q   <= 1'b0;
            din_q    <= 1'b0;
            fin_q    <= 1'b0;
        end else if (fin_now) begin
            state_q  <= S_IDLE;
            status_q <= fin_code;
            prog_n_q <= 1'b1;
            cclk_q   <= 1'b0;
            din_q    <= 1'b0;
            fin_q    <= 1'b1;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    rem_q    <= nbytes_i;
                    prog_n_q <= 1'b0;
                    state_q  <= S_PROG;
                end
                S_PROG: if (!init_n_s) begin
                    prog_n_q <= 1'b1;
                    state_q  <= S_REL;
                end
                S_REL: if (init_n_s) state_q <= S_CHECK;
                S_CHECK: begin
                    if (rem_q == '0) begin
                        cclk_q  <= 1'b0;
                        din_q   <= 1'b1;
                        state_q <= S_TCHK;
                    end else begin
                        state_q <= S_LOAD;
                    end
                end
                S_LOAD: if (s_valid_i) begin
                    sh_q    <= s_data_i;
                    rem_q   <= rem_q - CNT_ONE;
                    bit_q   <= '0;
                    cclk_q  <= 1'b0;
                    state_q <= S_CLKLO;
                end
                S_CLKLO: if (tick_hit) begin
                    din_q   <= sh_q[7];
                    state_q <= S_DATA;
                end
                S_DATA: if (tick_hit) begin
                    cclk_q  <= 1'b1;
                    state_q <= S_CLKHI;
                end
                S_CLKHI: if (tick_hit) begin
                    sh_q <= {sh_q[6:0], 1'b0};
                    if (bit_q == BIT_LAST) begin
                        state_q <= S_CHECK;
                    end else begin
                        bit_q   <= bit_q + 3'd1;
                        cclk_q  <= 1'b0;
                        state_q <= S_CLKLO;
                    end
                end
                S_TCHK: begin
                    cclk_q  <= 1'b1;
                    state_q <= S_THI;
                end
                S_THI: if (tick_hit) begin
                    cclk_q  <= 1'b0;
                    state_q <= S_TLO;
                end
                S_TLO: if (tick_hit) state_q <= S_TCHK;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign s_ready_o = (state_q == S_LOAD);
    assign busy_o    = (state_q != S_IDLE);
    assign prog_n_o  = prog_n_q;
    assign cclk_o    = cclk_q;
    assign din_o     = din_q;
    assign fin_o     = fin_q;
    assign status_o  = status_q;

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> prog_n_o && !cclk_o && !s_ready_o) else $error("idle pins"); // R1
    AST_PROG_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o && !cclk_o && !s_ready_o) else $error("program phase"); // R2
    AST_DIN_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o && $past(cclk_o) |-> $stable(din_o)) else $error("data moved on high clock"); // R4
    AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> prog_n_o && busy_o) else $error("ready outside load"); // R6
    AST_TAIL_DATA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_THI) |-> din_o) else $error("tail data low"); // R8
    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o) else $error("finish pulse too long"); // R10
    AST_FIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !busy_o && status_o <= 3'd4) else $error("finish while busy"); // R10
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && !$past(s_valid_i && s_ready_o) |-> $stable(rem_q))
        else $error("byte count changed mid-run"); // R11
endmodule

// File: tb/sscfg_loader_bench.sv
module sscfg_loader_bench;
    localparam int CLK_PER = 10;
    localparam int DLY     = 3;
    localparam int TMO     = 300;
    localparam int CW      = 16;

    typedef struct packed {
        logic [7:0] n;
        logic       go;
        logic       clr;
        logic [7:0] crc_at;
        logic [7:0] k;
        logic [2:0] st;
        logic [7:0] nb;
        logic [7:0] tail;
    } vec_t;

    // n, INIT answers low, INIT clears, load error after byte, DONE after k tail rises,
    // expected status, expected bytes, expected tail rises (255 = not checked)
    localparam vec_t VECS [0:7] = '{
        '{8'd4, 1'b1, 1'b1, 8'd0, 8'd0,   3'd0, 8'd4, 8'd0},
        '{8'd1, 1'b1, 1'b1, 8'd0, 8'd3,   3'd0, 8'd1, 8'd3},
        '{8'd6, 1'b1, 1'b1, 8'd0, 8'd5,   3'd0, 8'd6, 8'd5},
        '{8'd0, 1'b1, 1'b1, 8'd0, 8'd2,   3'd0, 8'd0, 8'd2},
        '{8'd3, 1'b0, 1'b1, 8'd0, 8'd0,   3'd1, 8'd0, 8'd0},
        '{8'd3, 1'b1, 1'b0, 8'd0, 8'd0,   3'd2, 8'd0, 8'd0},
        '{8'd5, 1'b1, 1'b1, 8'd2, 8'd0,   3'd3, 8'd2, 8'd0},
        '{8'd2, 1'b1, 1'b1, 8'd0, 8'd255, 3'd4, 8'd2, 8'd255}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, s_valid = 1'b0;
    logic [CW-1:0] nbytes = '0;
    logic [7:0] s_data, seed = 8'h00;
    logic s_ready, prog_n, cclk, din, busy, fin;
    logic init_n = 1'b1, done = 1'b0;
    logic [2:0] status;

    int errors = 0, checks = 0, cyc = 0, wd = 0;
    int acc = 0, fin_cnt = 0;
    logic mdl_clr = 1'b0;
    int m_n = 0, m_crc = 0, m_k = 0;
    logic m_go = 1'b1, m_clr = 1'b1;
    logic seen_prog = 1'b0, prev_ck = 1'b0;
    int m_bits = 0, m_cap = 0, rise_c = 0, fall_c = 0;
    int tail_rises = 0, tail_bad = 0, tmg_bad = 0, rises = 0;
    logic [7:0] sr = '0;
    logic [7:0] cap [0:15];

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [7:0] pat(int i, logic [7:0] s);
        return 8'(i * 53) ^ s ^ 8'(i << 5);
    endfunction

    assign s_data = pat(acc, seed);

    sscfg_loader #(.DLY_CYC(DLY), .TMO_CYC(TMO), .CNT_W(CW)) u_sscfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .nbytes_i(nbytes),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
        .prog_n_o(prog_n), .cclk_o(cclk), .din_o(din),
        .init_n_i(init_n), .done_i(done), .busy_o(busy), .fin_o(fin), .status_o(status));

    // Count accepted stream bytes.
    always @(posedge clk) begin
        if (mdl_clr) acc <= 0;
        else if (s_valid && s_ready) acc <= acc + 1;
    end

    // FPGA model, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdl_clr) begin
            seen_prog = 1'b0; init_n = 1'b1; done = 1'b0; m_bits = 0; m_cap = 0;
            tail_rises = 0; tail_bad = 0; tmg_bad = 0; rises = 0; fin_cnt = 0;
        end else begin
            if (fin) fin_cnt = fin_cnt + 1;
            if (cclk && !prev_ck) begin
                rises = rises + 1;
                if (m_cap < m_n) begin
                    if (m_bits != 0 && (cyc - fall_c) != 2*DLY) tmg_bad = tmg_bad + 1;
                    sr = {sr[6:0], din};
                    if (m_bits == 7) begin cap[m_cap] = sr; m_cap = m_cap + 1; m_bits = 0; end
                    else m_bits = m_bits + 1;
                end else begin
                    tail_rises = tail_rises + 1;
                    if (!din) tail_bad = tail_bad + 1;
                end
                rise_c = cyc;
            end
            if (!cclk && prev_ck) begin
                if (m_bits != 0 && (cyc - rise_c) != DLY) tmg_bad = tmg_bad + 1;
                fall_c = cyc;
            end
            if (!prog_n) begin
                seen_prog = 1'b1;
                init_n = m_go ? 1'b0 : 1'b1;
            end else if (seen_prog) begin
                init_n = m_clr ? !((m_crc != 0) && (m_cap >= m_crc)) : 1'b0;
            end
            if (seen_prog && m_cap >= m_n && m_k != 255 && tail_rises >= m_k) done = 1'b1;
        end
        prev_ck = cclk;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset(input int n, input logic go, input logic cl, input int crc, input int k);
        @(posedge clk); #1;
        m_n = n; m_go = go; m_clr = cl; m_crc = crc; m_k = k; mdl_clr = 1'b1;
        @(posedge clk); #1;
        mdl_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic launch(input int n, input logic [7:0] sd);
        seed = sd; nbytes = CW'(n); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_fin(input bit inj);
        for (int c = 0; c < 6000 && fin_cnt == 0; c++) begin
            @(posedge clk); #1;
            if (inj && c == 120) begin start = 1'b1; nbytes = CW'(7); end
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_bytes(input int nb, input logic [7:0] sd);
        chk(m_cap == nb, "R4", "bytes captured", m_cap, nb);
        for (int i = 0; i < nb && i < m_cap; i++)
            chk(cap[i] == pat(i, sd), "R4", "byte value MSB first", int'(cap[i]), int'(pat(i, sd)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(prog_n == 1'b1 && cclk == 1'b0 && s_ready == 1'b0, "R1", "reset pins", {prog_n, cclk, s_ready}, 3'b100);
        chk(busy == 1'b0 && fin == 1'b0, "R1", "reset busy/fin", {busy, fin}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(status == 3'd0, "R1", "reset status", status, 0);

        // Vector table walk.
        for (int r = 0; r < 8; r++) begin
            vec_t v;
            v = VECS[r];
            model_reset(int'(v.n), v.go, v.clr, int'(v.crc_at), int'(v.k));
            s_valid = 1'b1;
            launch(int'(v.n), 8'(r * 29 + 7));
            wait_fin(1'b0);
            chk(status == v.st, v.st == 0 ? "R8" : v.st == 1 ? "R2" : v.st == 2 ? "R3" : v.st == 3 ? "R7" : "R9",
                "status", status, int'(v.st));
            check_bytes(int'(v.nb), 8'(r * 29 + 7));
            chk(acc == int'(v.nb), "R6", "stream bytes taken", acc, int'(v.nb));
            chk(fin_cnt == 1, "R10", "finish pulses", fin_cnt, 1);
            chk(tmg_bad == 0, "R5", "bit phase lengths", tmg_bad, 0);
            chk(tail_bad == 0, "R8", "tail data high", tail_bad, 0);
            if (v.tail != 8'd255)
                chk(tail_rises == int'(v.tail), v.n == 0 ? "R12" : "R8", "tail pulses", tail_rises, int'(v.tail));
            if (v.st == 3'd4)
                chk(tail_rises > 0, "R9", "tail kept pulsing", tail_rises, 1);
            chk(busy == 1'b0 && prog_n == 1'b1, "R1", "idle after run", {busy, prog_n}, 1);
        end

        // R11: start while busy must not alter the run.
        model_reset(2, 1'b1, 1'b1, 0, 1);
        s_valid = 1'b1;
        launch(2, 8'h3C);
        wait_fin(1'b1);
        chk(status == 3'd0, "R11", "status with stray start", status, 0);
        chk(m_cap == 2 && acc == 2, "R11", "bytes with stray start", m_cap, 2);
        chk(fin_cnt == 1, "R11", "single run", fin_cnt, 1);
        chk(busy == 1'b0, "R11", "no second run", busy, 0);

        // R6: valid low stalls in the load state with no clocking.
        model_reset(1, 1'b1, 1'b1, 0, 1);
        s_valid = 1'b0;
        launch(1, 8'hC5);
        for (int c = 0; c < 400 && !s_ready; c++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(s_ready == 1'b1 && busy == 1'b1, "R6", "ready waiting", {s_ready, busy}, 3);
        chk(acc == 0 && rises == 0, "R6", "no clock while stalled", rises, 0);
        @(posedge clk); #1; s_valid = 1'b1;
        wait_fin(1'b0);
        chk(status == 3'd0, "R6", "status after stall", status, 0);
        check_bytes(1, 8'hC5);

        // R1: reset in the middle of a load returns pins to idle.
        model_reset(3, 1'b1, 1'b1, 0, 0);
        launch(3, 8'h11);
        repeat (60) @(posedge clk);
        #1; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(prog_n == 1'b1 && cclk == 1'b0 && s_ready == 1'b0 && busy == 1'b0, "R1", "mid-run reset pins",
            {prog_n, cclk, s_ready, busy}, 4'b1000);
        chk(status == 3'd0, "R1", "mid-run reset status", status, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule